// File: doc/BRIEF.md
# Operand Forwarding and Load-Use Interlock

This block sits beside the decode stage of a five-stage in-order pipeline (fetch, decode, execute, memory, writeback). It keeps a shadow copy of the destination register and the result kind for the instructions in execute, memory and writeback. It compares the two source registers of the instruction in decode with those copies. For each operand it picks the youngest in-flight producer, or the register file value when none matches. A small operand datapath applies those selects, so the operands a consumer receives can be seen directly at the ports.

With the full bypass network (the default), the only dependence that cannot be met in time is a load still in execute. In that case the block raises `stall`. The surrounding pipeline then holds fetch and decode, and the shadow execute slot takes a no-op with every enable low. A reduced configuration models a pipeline where the only bypass is from execute to operand A, and only for plain ALU results. That configuration stalls for every other dependence, and execute-stage writers are split into a forwardable class and a must-stall class.

The result kind is a 2-bit code: 0 = none (no write), 1 = ALU or ALU-immediate, 2 = load, 3 = link write (jump-and-link forms). The select code on `sel_a`/`sel_b` is 0 = register file, 1 = execute result, 2 = memory-stage value, 3 = writeback value.

Top module: `fwd_stall_unit`

## Requirements
- R1: Synchronous active-low reset empties all three shadow stages (kind 0). After reset, `stall` is 0, both selects are 0, and `opnd_a`/`opnd_b` equal `rf_rs_val`/`rf_rt_val`.
- R2: When an enabled source register matches the execute-stage destination, and that instruction has kind 1 or 3 and a nonzero destination, the select is 1 and the operand equals `ex_result` in the same cycle, with no stall. A dependent ALU chain therefore issues one instruction per cycle.
- R3: A match in the memory stage gives select 2. The operand is the execute result captured one cycle earlier, or `mem_rdata` when the memory-stage kind is 2. A match in writeback gives select 3 and the value the memory stage held one cycle earlier.
- R4: When several stages match, execute wins over memory, and memory wins over writeback. The rs (A) and rt (B) operands are selected independently.
- R5: Register 0 is never forwarded and never causes a stall, as a source or as a destination.
- R6: In full-bypass mode, `stall` is 1 exactly when the execute stage holds kind 2 with a nonzero destination that equals rs with `dec_rs_en` set, or rt with `dec_rt_en` set. A source whose read-enable is low never matches.
- R7: In a cycle with `stall` high, the execute shadow slot loads a no-op (kind 0). The held decode instruction therefore sees no execute-stage producer in the following cycle.
- R8: In full-bypass mode, a kind-3 link write in execute is forwarded like an ALU result and does not stall.
- R9: With `FULL_BYPASS` = 0, only operand A may take select 1, and only from a kind-1 producer, while `sel_b` stays 0. The block stalls when an enabled rs matches execute of kind 2 or 3, or matches any memory or writeback writer, or when an enabled rt matches any writer in any of the three stages.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dec_rs | input | AW | Decode source register A |
| dec_rs_en | input | 1 | Decode instruction reads source A |
| dec_rt | input | AW | Decode source register B |
| dec_rt_en | input | 1 | Decode instruction reads source B |
| dec_dest | input | AW | Decode destination register |
| dec_kind | input | 2 | Decode result kind (0 none, 1 ALU, 2 load, 3 link) |
| rf_rs_val | input | DW | Register file value for source A |
| rf_rt_val | input | DW | Register file value for source B |
| ex_result | input | DW | Result (ALU output or link address) of the execute-stage instruction |
| mem_rdata | input | DW | Load data read by the memory-stage instruction |
| stall | output | 1 | Hold fetch and decode; bubble into execute |
| sel_a | output | 2 | Operand A source select |
| sel_b | output | 2 | Operand B source select |
| opnd_a | output | DW | Selected operand A |
| opnd_b | output | DW | Selected operand B |

## Verification
The stall and the forwarding select of the other operand can be active in the same cycle. A consumer can depend on a load in execute through rs while its rt depends on an older ALU result in the memory stage. The load-use scenario sets this up: it issues an ALU write, then a load, then a consumer that reads both. In the stall cycle, the bench expects `stall` high and `sel_b` already 2 with the ALU value. In the next cycle, it expects `sel_a` = 2 with the load data and `sel_b` = 3. That second check would also show 1 instead of 3 if the bubble had not been a no-op.

// File: rtl/fsu_pkg.sv
package fsu_pkg;

    typedef enum logic [1:0] {
        K_NONE = 2'd0,
        K_ALU  = 2'd1,
        K_LOAD = 2'd2,
        K_LINK = 2'd3
    } kind_e;

    typedef enum logic [1:0] {
        SRC_RF  = 2'd0,
        SRC_EX  = 2'd1,
        SRC_MEM = 2'd2,
        SRC_WB  = 2'd3
    } src_e;

endpackage

// File: rtl/fsu_shadow.sv
module fsu_shadow
    import fsu_pkg::*;
#(
    parameter int AW = 5,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          stall,
    input  logic [AW-1:0] dec_dest,
    input  kind_e         dec_kind,
    input  logic [DW-1:0] ex_result,
    input  logic [DW-1:0] mem_rdata,
    output logic [AW-1:0] e_dest,
    output kind_e         e_kind,
    output logic [AW-1:0] m_dest,
    output kind_e         m_kind,
    output logic [DW-1:0] m_val,
    output logic [AW-1:0] w_dest,
    output kind_e         w_kind,
    output logic [DW-1:0] w_val
);

    logic [DW-1:0] m_res;

    // execute slot: a stall injects a no-op with every enable low
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            e_kind <= K_NONE;
            e_dest <= '0;
        end else if (stall) begin
            e_kind <= K_NONE;
            e_dest <= '0;
        end else begin
            e_kind <= dec_kind;
            e_dest <= dec_dest;
        end
    end

    // memory and writeback slots always advance
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            m_kind <= K_NONE;
            m_dest <= '0;
            m_res  <= '0;
            w_kind <= K_NONE;
            w_dest <= '0;
            w_val  <= '0;
        end else begin
            m_kind <= e_kind;
            m_dest <= e_dest;
            m_res  <= ex_result;
            w_kind <= m_kind;
            w_dest <= m_dest;
            w_val  <= m_val;
        end
    end

    assign m_val = (m_kind == K_LOAD) ? mem_rdata : m_res;

endmodule

// File: rtl/fsu_hazard.sv
module fsu_hazard
    import fsu_pkg::*;
#(
    parameter int AW          = 5,
    parameter bit FULL_BYPASS = 1'b1
) (
    input  logic [AW-1:0] dec_rs,
    input  logic          dec_rs_en,
    input  logic [AW-1:0] dec_rt,
    input  logic          dec_rt_en,
    input  logic [AW-1:0] e_dest,
    input  kind_e         e_kind,
    input  logic [AW-1:0] m_dest,
    input  kind_e         m_kind,
    input  logic [AW-1:0] w_dest,
    input  kind_e         w_kind,
    output logic          stall,
    output src_e          sel_a,
    output src_e          sel_b
);

    logic e_wr, m_wr, w_wr;

    assign e_wr = (e_kind != K_NONE) && (e_dest != '0);
    assign m_wr = (m_kind != K_NONE) && (m_dest != '0);
    assign w_wr = (w_kind != K_NONE) && (w_dest != '0);

    function automatic src_e pick(
        input logic          en,
        input logic [AW-1:0] r,
        input logic          hit_e,
        input logic [AW-1:0] de,
        input logic          hit_m,
        input logic [AW-1:0] dm,
        input logic          hit_w,
        input logic [AW-1:0] dw
    );
        if (!en || r == '0)          return SRC_RF;
        if (hit_e && r == de)        return SRC_EX;
        if (hit_m && r == dm)        return SRC_MEM;
        if (hit_w && r == dw)        return SRC_WB;
        return SRC_RF;
    endfunction

    generate
        if (FULL_BYPASS) begin : g_full
            logic e_fwd, e_ld;
            assign e_fwd = e_wr && (e_kind == K_ALU || e_kind == K_LINK);
            assign e_ld  = e_wr && (e_kind == K_LOAD);
            always_comb begin
                sel_a = pick(dec_rs_en, dec_rs, e_fwd, e_dest, m_wr, m_dest, w_wr, w_dest);
                sel_b = pick(dec_rt_en, dec_rt, e_fwd, e_dest, m_wr, m_dest, w_wr, w_dest);
                stall = e_ld && ((dec_rs_en && dec_rs == e_dest) ||
                                 (dec_rt_en && dec_rt == e_dest));
            end
        end else begin : g_lite
            logic e_fwd, e_hold;
            assign e_fwd  = e_wr && (e_kind == K_ALU);
            assign e_hold = e_wr && (e_kind == K_LOAD || e_kind == K_LINK);
            always_comb begin
                sel_a = pick(dec_rs_en, dec_rs, e_fwd, e_dest, 1'b0, m_dest, 1'b0, w_dest);
                sel_b = SRC_RF;
                stall = (dec_rs_en && ((e_hold && dec_rs == e_dest) ||
                                       (m_wr   && dec_rs == m_dest) ||
                                       (w_wr   && dec_rs == w_dest))) ||
                        (dec_rt_en && ((e_wr   && dec_rt == e_dest) ||
                                       (m_wr   && dec_rt == m_dest) ||
                                       (w_wr   && dec_rt == w_dest)));
            end
        end
    endgenerate

endmodule

// File: rtl/fsu_opmux.sv
module fsu_opmux
    import fsu_pkg::*;
#(
    parameter int DW = 32
) (
    input  src_e          sel,
    input  logic [DW-1:0] rf_val,
    input  logic [DW-1:0] e_val,
    input  logic [DW-1:0] m_val,
    input  logic [DW-1:0] w_val,
    output logic [DW-1:0] y
);

    always_comb begin
        unique case (sel)
            SRC_RF:  y = rf_val;
            SRC_EX:  y = e_val;
            SRC_MEM: y = m_val;
            SRC_WB:  y = w_val;
            default: y = rf_val;
        endcase
    end

endmodule

// File: rtl/fwd_stall_unit.sv
module fwd_stall_unit
    import fsu_pkg::*;
#(
    parameter int AW          = 5,
    parameter int DW          = 32,
    parameter bit FULL_BYPASS = 1'b1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] dec_rs,
    input  logic          dec_rs_en,
    input  logic [AW-1:0] dec_rt,
    input  logic          dec_rt_en,
    input  logic [AW-1:0] dec_dest,
    input  logic [1:0]    dec_kind,
    input  logic [DW-1:0] rf_rs_val,
    input  logic [DW-1:0] rf_rt_val,
    input  logic [DW-1:0] ex_result,
    input  logic [DW-1:0] mem_rdata,
    output logic          stall,
    output logic [1:0]    sel_a,
    output logic [1:0]    sel_b,
    output logic [DW-1:0] opnd_a,
    output logic [DW-1:0] opnd_b
);

    logic [AW-1:0] e_dest, m_dest, w_dest;
    kind_e         e_kind, m_kind, w_kind;
    logic [DW-1:0] m_val, w_val;
    src_e          src_a, src_b;

    fsu_shadow #(.AW(AW), .DW(DW)) u_shadow (
        .clk       (clk),
        .rst_n     (rst_n),
        .stall     (stall),
        .dec_dest  (dec_dest),
        .dec_kind  (kind_e'(dec_kind)),
        .ex_result (ex_result),
        .mem_rdata (mem_rdata),
        .e_dest    (e_dest),
        .e_kind    (e_kind),
        .m_dest    (m_dest),
        .m_kind    (m_kind),
        .m_val     (m_val),
        .w_dest    (w_dest),
        .w_kind    (w_kind),
        .w_val     (w_val)
    );

    fsu_hazard #(.AW(AW), .FULL_BYPASS(FULL_BYPASS)) u_hazard (
        .dec_rs    (dec_rs),
        .dec_rs_en (dec_rs_en),
        .dec_rt    (dec_rt),
        .dec_rt_en (dec_rt_en),
        .e_dest    (e_dest),
        .e_kind    (e_kind),
        .m_dest    (m_dest),
        .m_kind    (m_kind),
        .w_dest    (w_dest),
        .w_kind    (w_kind),
        .stall     (stall),
        .sel_a     (src_a),
        .sel_b     (src_b)
    );

    fsu_opmux #(.DW(DW)) u_mux_a (
        .sel    (src_a),
        .rf_val (rf_rs_val),
        .e_val  (ex_result),
        .m_val  (m_val),
        .w_val  (w_val),
        .y      (opnd_a)
    );

    fsu_opmux #(.DW(DW)) u_mux_b (
        .sel    (src_b),
        .rf_val (rf_rt_val),
        .e_val  (ex_result),
        .m_val  (m_val),
        .w_val  (w_val),
        .y      (opnd_b)
    );

    assign sel_a = src_a;
    assign sel_b = src_b;

endmodule

// File: rtl/fsu_chk.sv
module fsu_chk #(
    parameter int AW   = 5,
    parameter int DW   = 32,
    parameter bit FULL = 1'b1
) (
    input logic          clk,
    input logic          rst_n,
    input logic          stall,
    input logic [1:0]    sel_a,
    input logic [1:0]    sel_b,
    input logic [AW-1:0] dec_rs,
    input logic          dec_rs_en,
    input logic [AW-1:0] dec_rt,
    input logic          dec_rt_en,
    input logic [DW-1:0] opnd_a,
    input logic [DW-1:0] ex_result,
    input logic [1:0]    e_kind,
    input logic [1:0]    m_kind,
    input logic [1:0]    w_kind
);

    assert_bubble_after_stall_R7: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> (e_kind == 2'd0));

    assert_no_zero_fwd_a_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_a != 2'd0) |-> (dec_rs != '0 && dec_rs_en));

    assert_no_zero_fwd_b_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_b != 2'd0) |-> (dec_rt != '0 && dec_rt_en));

    assert_ex_path_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_a == 2'd1) |-> (opnd_a == ex_result));

    assert_shadow_advance_R3: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (w_kind == $past(m_kind)));

    assert_stall_needs_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (FULL && stall) |-> (dec_rs_en || dec_rt_en));

endmodule

bind fwd_stall_unit fsu_chk #(.AW(AW), .DW(DW), .FULL(FULL_BYPASS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .stall     (stall),
    .sel_a     (sel_a),
    .sel_b     (sel_b),
    .dec_rs    (dec_rs),
    .dec_rs_en (dec_rs_en),
    .dec_rt    (dec_rt),
    .dec_rt_en (dec_rt_en),
    .opnd_a    (opnd_a),
    .ex_result (ex_result),
    .e_kind    (e_kind),
    .m_kind    (m_kind),
    .w_kind    (w_kind)
);

// File: tb/fwd_stall_unit_test.sv
module fwd_stall_unit_test;

    localparam int AW = 5;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] dec_rs = '0, dec_rt = '0, dec_dest = '0;
    logic          dec_rs_en = 1'b0, dec_rt_en = 1'b0;
    logic [1:0]    dec_kind = 2'd0;
    logic [DW-1:0] rf_rs_val = 32'hAAAA_0001, rf_rt_val = 32'hBBBB_0002;
    logic [DW-1:0] ex_result = '0, mem_rdata = '0;

    logic          stall, l_stall;
    logic [1:0]    sel_a, sel_b, l_sel_a, l_sel_b;
    logic [DW-1:0] opnd_a, opnd_b, l_opnd_a, l_opnd_b;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    fwd_stall_unit #(.AW(AW), .DW(DW), .FULL_BYPASS(1'b1)) uut (
        .clk(clk), .rst_n(rst_n), .dec_rs(dec_rs), .dec_rs_en(dec_rs_en),
        .dec_rt(dec_rt), .dec_rt_en(dec_rt_en), .dec_dest(dec_dest), .dec_kind(dec_kind),
        .rf_rs_val(rf_rs_val), .rf_rt_val(rf_rt_val), .ex_result(ex_result),
        .mem_rdata(mem_rdata), .stall(stall), .sel_a(sel_a), .sel_b(sel_b),
        .opnd_a(opnd_a), .opnd_b(opnd_b));

    fwd_stall_unit #(.AW(AW), .DW(DW), .FULL_BYPASS(1'b0)) uut_lite (
        .clk(clk), .rst_n(rst_n), .dec_rs(dec_rs), .dec_rs_en(dec_rs_en),
        .dec_rt(dec_rt), .dec_rt_en(dec_rt_en), .dec_dest(dec_dest), .dec_kind(dec_kind),
        .rf_rs_val(rf_rs_val), .rf_rt_val(rf_rt_val), .ex_result(ex_result),
        .mem_rdata(mem_rdata), .stall(l_stall), .sel_a(l_sel_a), .sel_b(l_sel_b),
        .opnd_a(l_opnd_a), .opnd_b(l_opnd_b));

    task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // present one decode instruction after the falling edge, settle, return
    task automatic issue(input logic [AW-1:0] rs, input logic rs_en,
                         input logic [AW-1:0] rt, input logic rt_en,
                         input logic [AW-1:0] dest, input logic [1:0] kind,
                         input logic [DW-1:0] exr, input logic [DW-1:0] mrd);
        @(negedge clk);
        dec_rs = rs; dec_rs_en = rs_en; dec_rt = rt; dec_rt_en = rt_en;
        dec_dest = dest; dec_kind = kind; ex_result = exr; mem_rdata = mrd;
        #1;
    endtask

    task automatic do_reset;
        @(negedge clk);
        rst_n = 1'b0;
        dec_rs_en = 1'b0; dec_rt_en = 1'b0; dec_kind = 2'd0; dec_dest = '0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_reset;
        do_reset();
        issue(5'd1, 1'b1, 5'd2, 1'b1, 5'd0, 2'd0, 32'h0, 32'h0);
        chk("R1 stall", stall, 0);
        chk("R1 sel_a", sel_a, 0);
        chk("R1 sel_b", sel_b, 0);
        chk("R1 opnd_a", opnd_a, rf_rs_val);
        chk("R1 opnd_b", opnd_b, rf_rt_val);
    endtask

    task automatic t_alu_chain;
        do_reset();
        issue(5'd0, 1'b0, 5'd0, 1'b0, 5'd1, 2'd1, 32'd0, 32'd0);
        issue(5'd1, 1'b1, 5'd0, 1'b0, 5'd2, 2'd1, 32'd100, 32'd0);
        chk("R2 sel_a E", sel_a, 1);
        chk("R2 opnd_a E", opnd_a, 100);
        chk("R2 no stall", stall, 0);
        issue(5'd2, 1'b1, 5'd1, 1'b1, 5'd3, 2'd1, 32'd200, 32'd0);
        chk("R2 sel_a E chain", sel_a, 1);
        chk("R2 opnd_a chain", opnd_a, 200);
        chk("R3 sel_b M", sel_b, 2);
        chk("R3 opnd_b M", opnd_b, 100);
        issue(5'd0, 1'b0, 5'd1, 1'b1, 5'd0, 2'd0, 32'd300, 32'd0);
        chk("R3 sel_b W", sel_b, 3);
        chk("R3 opnd_b W", opnd_b, 100);
    endtask

    task automatic t_priority;
        do_reset();
        issue(5'd0, 1'b0, 5'd0, 1'b0, 5'd3, 2'd1, 32'd0, 32'd0);
        issue(5'd0, 1'b0, 5'd0, 1'b0, 5'd3, 2'd1, 32'd10, 32'd0);
        issue(5'd0, 1'b0, 5'd0, 1'b0, 5'd3, 2'd1, 32'd20, 32'd0);
        issue(5'd3, 1'b1, 5'd3, 1'b1, 5'd0, 2'd1, 32'd30, 32'd0);
        chk("R4 E over M/W a", sel_a, 1);
        chk("R4 E value", opnd_a, 30);
        chk("R4 E over M/W b", sel_b, 1);
        issue(5'd3, 1'b1, 5'd0, 1'b0, 5'd0, 2'd0, 32'd0, 32'd0);
        chk("R4 M over W", sel_a, 2);
        chk("R4 M value", opnd_a, 30);
        issue(5'd0, 1'b0, 5'd3, 1'b1, 5'd0, 2'd0, 32'd0, 32'd0);
        chk("R4 W only", sel_b, 3);
        chk("R4 W value", opnd_b, 30);
    endtask

    task automatic t_load_use;
        do_reset();
        issue(5'd0, 1'b0, 5'd0, 1'b0, 5'd7, 2'd1, 32'd0, 32'd0);
        issue(5'd0, 1'b0, 5'd0, 1'b0, 5'd5, 2'd2, 32'd55, 32'd0);
        issue(5'd5, 1'b1, 5'd7, 1'b1, 5'd7, 2'd1, 32'd0, 32'd0);
        chk("R6 load-use stall", stall, 1);
        chk("R3 sel_b M during stall", sel_b, 2);
        chk("R3 opnd_b M during stall", opnd_b, 55);
        issue(5'd5, 1'b1, 5'd7, 1'b1, 5'd7, 2'd1, 32'd0, 32'd77);
        chk("R6 stall released", stall, 0);
        chk("R3 load data sel M", sel_a, 2);
        chk("R3 load data value", opnd_a, 77);
        chk("R7 bubble in E, sel_b W", sel_b, 3);
        chk("R7 opnd_b W", opnd_b, 55);
        issue(5'd5, 1'b1, 5'd0, 1'b0, 5'd0, 2'd0, 32'd0, 32'd0);
        chk("R3 load in W sel", sel_a, 3);
        chk("R3 load in W value", opnd_a, 77);
        do_reset();
        issue(5'd0, 1'b0, 5'd0, 1'b0, 5'd5, 2'd2, 32'd0, 32'd0);
        issue(5'd5, 1'b0, 5'd5, 1'b0, 5'd0, 2'd0, 32'd0, 32'd0);
        chk("R6 read-enable low no stall", stall, 0);
        chk("R6 read-enable low sel_a", sel_a, 0);
    endtask

    task automatic t_zero;
        do_reset();
        issue(5'd0, 1'b0, 5'd0, 1'b0, 5'd0, 2'd1, 32'd0, 32'd0);
        issue(5'd0, 1'b1, 5'd0, 1'b0, 5'd0, 2'd2, 32'd9, 32'd0);
        chk("R5 r0 not forwarded", sel_a, 0);
        chk("R5 r0 operand from RF", opnd_a, rf_rs_val);
        issue(5'd0, 1'b1, 5'd0, 1'b1, 5'd0, 2'd0, 32'd0, 32'd0);
        chk("R5 load to r0 no stall", stall, 0);
        chk("R5 r0 sel_b", sel_b, 0);
    endtask

    task automatic t_link;
        do_reset();
        issue(5'd0, 1'b0, 5'd0, 1'b0, 5'd31, 2'd3, 32'd0, 32'd0);
        issue(5'd31, 1'b1, 5'd0, 1'b0, 5'd0, 2'd0, 32'h400, 32'd0);
        chk("R8 link no stall", stall, 0);
        chk("R8 link sel E", sel_a, 1);
        chk("R8 link value", opnd_a, 32'h400);
        chk("R9 lite link stalls", l_stall, 1);
    endtask

    task automatic t_lite;
        do_reset();
        issue(5'd0, 1'b0, 5'd0, 1'b0, 5'd1, 2'd1, 32'd0, 32'd0);
        chk("R9 lite idle", l_stall, 0);
        issue(5'd1, 1'b1, 5'd0, 1'b0, 5'd0, 2'd0, 32'd5, 32'd0);
        chk("R9 lite E->A sel", l_sel_a, 1);
        chk("R9 lite E->A value", l_opnd_a, 5);
        chk("R9 lite E->A no stall", l_stall, 0);
        issue(5'd0, 1'b0, 5'd1, 1'b1, 5'd0, 2'd0, 32'd0, 32'd0);
        chk("R9 lite rt vs M stalls", l_stall, 1);
        chk("R9 lite sel_b RF", l_sel_b, 0);
        chk("R3 full rt vs M forwards", sel_b, 2);
        chk("R6 full no stall for ALU in M", stall, 0);
        do_reset();
        issue(5'd0, 1'b0, 5'd0, 1'b0, 5'd1, 2'd1, 32'd0, 32'd0);
        issue(5'd0, 1'b0, 5'd1, 1'b1, 5'd0, 2'd0, 32'd8, 32'd0);
        chk("R9 lite rt vs E ALU stalls", l_stall, 1);
        chk("R2 full rt vs E forwards", sel_b, 1);
    endtask

    initial begin
        t_reset();
        t_alu_chain();
        t_priority();
        t_load_use();
        t_zero();
        t_link();
        t_lite();
        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #400000;
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule